// File: doc/BRIEF.md
# Register Rename Unit with Free List

This block sits between decode and the reorder buffer of an out-of-order core. It keeps a speculative table that maps each architectural register to the physical tag that holds its newest value. It also keeps a pool of unused physical tags. For every instruction presented, it translates both source registers into physical tags. When the instruction writes a register, the block takes a fresh tag from the pool, records it as the new home of the destination, and reports the tag the destination held before. The reorder buffer stores that previous tag with the instruction.

When an instruction retires, the reorder buffer hands back the instruction's destination, its new tag and its previous tag. The previous tag returns to the pool, and a second table (the committed map) records the new mapping. A flush throws away all speculative state. It copies the committed map into the speculative table and refills the pool with every physical tag that the committed map does not reference, in ascending order. The default size is 8 architectural and 16 physical registers.

All rename outputs are combinational from the request inputs and the current state. Table and pool updates take effect at the next rising clock edge.

Top module: `reg_rename`

## Requirements
- R1: After reset, architectural register i maps to physical tag i, and the pool holds tags 8 to 15 in that order.
- R2: `ren_tag_a` and `ren_tag_b` always show the current mapping of `ren_src_a` and `ren_src_b`. When an instruction reads the register it also writes, it sees the mapping from before its own rename.
- R3: An accepted request with `ren_has_dst`=1 receives the tag at the head of the pool on `ren_new_tag`. From the next cycle on, the destination maps to that tag.
- R4: For a request with `ren_has_dst`=1, `ren_prev_tag` shows the destination's mapping before the rename, and `ren_prev_valid` is 1.
- R5: A request with `ren_has_dst`=0 is always ready, takes nothing from the pool, drives `ren_prev_valid` low and leaves the table unchanged.
- R6: `ren_ready` is 0 for a request with `ren_has_dst`=1 while the pool is empty. A request that is not ready changes no state.
- R7: A commit with `cmt_has_dst`=1 appends `cmt_prev_tag` to the tail of the pool. That tag is handed out after every tag that was already in the pool.
- R8: An allocation and a release in the same cycle both take effect.
- R9: A flush sets the speculative table equal to the committed map. It refills the pool with the unreferenced tags in ascending order. Any rename request in that cycle is refused (`ren_ready`=0).
- R10: A commit in the same cycle as a flush is applied to the committed map before the restore.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ren_valid | input | 1 | Rename request present |
| ren_src_a | input | 3 | First source architectural register |
| ren_src_b | input | 3 | Second source architectural register |
| ren_has_dst | input | 1 | Request writes a destination |
| ren_dst | input | 3 | Destination architectural register |
| ren_ready | output | 1 | Request can be accepted this cycle |
| ren_tag_a | output | 4 | Physical tag of first source |
| ren_tag_b | output | 4 | Physical tag of second source |
| ren_new_tag | output | 4 | Tag allocated to the destination (0 when none) |
| ren_prev_tag | output | 4 | Previous tag of the destination (0 when none) |
| ren_prev_valid | output | 1 | `ren_prev_tag` is meaningful |
| cmt_valid | input | 1 | An instruction retires |
| cmt_has_dst | input | 1 | Retiring instruction wrote a destination |
| cmt_dst | input | 3 | Retiring destination architectural register |
| cmt_new_tag | input | 4 | Tag the retiring instruction allocated |
| cmt_prev_tag | input | 4 | Tag to return to the pool |
| flush | input | 1 | Restore speculative state from the committed map |

## Verification
A corrupted table entry shows up on the source tag outputs as soon as any instruction reads that register. A pool-pointer or count error shows up on the next allocation, either as a wrong `ren_new_tag` or as `ren_ready` at the wrong level. The bench keeps its own model of both tables and the pool and compares all outputs on every cycle. Any divergence is therefore reported at the first request that touches the bad state. A flush re-derives the whole state, so one short sweep of reads after each flush confirms the restore.

// File: rtl/rename_pkg.sv
// Package: rename_pkg
// Shared types for the register rename unit.
// Assumes nothing beyond SystemVerilog packages.
package rename_pkg;
    // Free-list operation for one cycle, encoded as {push, pop}.
    typedef enum logic [1:0] {
        FL_HOLD = 2'b00,
        FL_POP  = 2'b01,
        FL_PUSH = 2'b10,
        FL_BOTH = 2'b11
    } fl_op_e;
endpackage

// File: rtl/rename_free_list.sv
// Module: rename_free_list
// Circular FIFO of free physical tags with an occupancy count.
// Pop takes from the head and push appends at the tail; both may happen in one cycle.
// Rebuild refills the FIFO in ascending order with every tag whose bit in used_mask is clear.
// Assumes: the caller never pops when empty, and never pushes when full without also popping.
// Assumes: NUM_PHYS - NUM_ARCH >= 2.
module rename_free_list
    import rename_pkg::*;
#(
    parameter int NUM_PHYS = 16,
    parameter int NUM_ARCH = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        pop,
    input  logic                        push,
    input  logic [$clog2(NUM_PHYS)-1:0] push_tag,
    input  logic                        rebuild,
    input  logic [NUM_PHYS-1:0]         used_mask,
    output logic [$clog2(NUM_PHYS)-1:0] head_tag,
    output logic                        empty
);
    localparam int TW    = $clog2(NUM_PHYS);
    localparam int DEPTH = NUM_PHYS - NUM_ARCH;
    localparam int PW    = $clog2(DEPTH);
    localparam int CW    = $clog2(DEPTH + 1);

    logic [TW-1:0] slots    [DEPTH];
    logic [TW-1:0] rb_slots [DEPTH];
    logic [PW-1:0] head, tail;
    logic [CW-1:0] count, rb_count;
    fl_op_e        op;

    // Advance a ring pointer with wrap-around.
    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Decode the cycle's operation from the request bits.
    always_comb op = fl_op_e'({push, pop});

    // Gather the unreferenced tags in ascending order for a rebuild.
    always_comb begin
        int k;
        k = 0;
        for (int j = 0; j < DEPTH; j++) rb_slots[j] = '0;
        for (int p = 0; p < NUM_PHYS; p++) begin
            if (!used_mask[p] && k < DEPTH) begin
                rb_slots[k] = TW'(p);
                k++;
            end
        end
        rb_count = CW'(k);
    end

    // Ring storage, pointers and count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < DEPTH; j++) slots[j] <= TW'(NUM_ARCH + j);
            head  <= '0;
            tail  <= '0;
            count <= CW'(DEPTH);
        end else if (rebuild) begin
            for (int j = 0; j < DEPTH; j++) slots[j] <= rb_slots[j];
            head  <= '0;
            tail  <= (rb_count == CW'(DEPTH)) ? '0 : PW'(rb_count);
            count <= rb_count;
        end else begin
            case (op)
                FL_POP: begin
                    head  <= bump(head);
                    count <= count - 1'b1;
                end
                FL_PUSH: begin
                    slots[tail] <= push_tag;
                    tail        <= bump(tail);
                    count       <= count + 1'b1;
                end
                FL_BOTH: begin
                    slots[tail] <= push_tag;
                    tail        <= bump(tail);
                    head        <= bump(head);
                end
                default: ;
            endcase
        end
    end

    // Head tag and empty flag seen by the allocator.
    always_comb begin
        head_tag = slots[head];
        empty    = (count == '0);
    end

    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !rebuild) |-> (count != '0));
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !rebuild) |-> (count < CW'(DEPTH)));
    assert_pair_keeps_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !rebuild) |=> (count == $past(count)));
    assert_rebuild_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rebuild |=> (count == CW'(DEPTH)));
endmodule

// File: rtl/rename_map.sv
// Module: rename_map
// Speculative rename table plus committed-map copy.
// Three combinational read ports; one speculative write port; one commit write port.
// Flush copies the committed map, including any same-cycle commit, into the speculative table.
// used_mask marks every tag the post-commit committed map references.
// Assumes: the committed map always holds distinct tags.
module rename_map #(
    parameter int NUM_ARCH = 8,
    parameter int NUM_PHYS = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [$clog2(NUM_ARCH)-1:0] rd_a,
    input  logic [$clog2(NUM_ARCH)-1:0] rd_b,
    input  logic [$clog2(NUM_ARCH)-1:0] rd_d,
    output logic [$clog2(NUM_PHYS)-1:0] tag_a,
    output logic [$clog2(NUM_PHYS)-1:0] tag_b,
    output logic [$clog2(NUM_PHYS)-1:0] tag_d,
    input  logic                        wr_en,
    input  logic [$clog2(NUM_ARCH)-1:0] wr_idx,
    input  logic [$clog2(NUM_PHYS)-1:0] wr_tag,
    input  logic                        cm_en,
    input  logic [$clog2(NUM_ARCH)-1:0] cm_idx,
    input  logic [$clog2(NUM_PHYS)-1:0] cm_tag,
    input  logic                        flush,
    output logic [NUM_PHYS-1:0]         used_mask
);
    localparam int TW = $clog2(NUM_PHYS);

    logic [TW-1:0] spec    [NUM_ARCH];
    logic [TW-1:0] cmt     [NUM_ARCH];
    logic [TW-1:0] cmt_nxt [NUM_ARCH];

    // Read ports: the current table, before this cycle's write.
    always_comb begin
        tag_a = spec[rd_a];
        tag_b = spec[rd_b];
        tag_d = spec[rd_d];
    end

    // Committed map as it will be after this cycle's commit.
    always_comb begin
        for (int i = 0; i < NUM_ARCH; i++) cmt_nxt[i] = cmt[i];
        if (cm_en) cmt_nxt[cm_idx] = cm_tag;
    end

    // Mark the tags the post-commit map references.
    always_comb begin
        used_mask = '0;
        for (int i = 0; i < NUM_ARCH; i++) used_mask[cmt_nxt[i]] = 1'b1;
    end

    // Committed map register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ARCH; i++) cmt[i] <= TW'(i);
        end else begin
            for (int i = 0; i < NUM_ARCH; i++) cmt[i] <= cmt_nxt[i];
        end
    end

    // Speculative table: restored on flush, otherwise written by rename.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ARCH; i++) spec[i] <= TW'(i);
        end else if (flush) begin
            for (int i = 0; i < NUM_ARCH; i++) spec[i] <= cmt_nxt[i];
        end else if (wr_en) begin
            spec[wr_idx] <= wr_tag;
        end
    end

    assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !flush) |=> (spec[$past(wr_idx)] == $past(wr_tag)));
    assert_commit_before_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_en && flush) |=> (spec[$past(cm_idx)] == $past(cm_tag)));
endmodule

// File: rtl/reg_rename.sv
// Module: reg_rename
// Top of the register rename unit.
// Translates sources, allocates a destination tag, reports the previous mapping,
// returns retired tags to the free list and restores state on flush.
// Assumes: commit fields come from the reorder buffer in program order,
// and a flush discards every unretired instruction.
module reg_rename #(
    parameter int NUM_ARCH = 8,
    parameter int NUM_PHYS = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ren_valid,
    input  logic [$clog2(NUM_ARCH)-1:0] ren_src_a,
    input  logic [$clog2(NUM_ARCH)-1:0] ren_src_b,
    input  logic                        ren_has_dst,
    input  logic [$clog2(NUM_ARCH)-1:0] ren_dst,
    output logic                        ren_ready,
    output logic [$clog2(NUM_PHYS)-1:0] ren_tag_a,
    output logic [$clog2(NUM_PHYS)-1:0] ren_tag_b,
    output logic [$clog2(NUM_PHYS)-1:0] ren_new_tag,
    output logic [$clog2(NUM_PHYS)-1:0] ren_prev_tag,
    output logic                        ren_prev_valid,
    input  logic                        cmt_valid,
    input  logic                        cmt_has_dst,
    input  logic [$clog2(NUM_ARCH)-1:0] cmt_dst,
    input  logic [$clog2(NUM_PHYS)-1:0] cmt_new_tag,
    input  logic [$clog2(NUM_PHYS)-1:0] cmt_prev_tag,
    input  logic                        flush
);
    localparam int TW = $clog2(NUM_PHYS);

    logic [TW-1:0]       head_tag, dst_old;
    logic                fl_empty, alloc, release_tag, cm_en;
    logic [NUM_PHYS-1:0] used_mask;

    // Handshake and per-cycle control.
    always_comb begin
        ren_ready   = !flush && (!ren_has_dst || !fl_empty);
        alloc       = ren_valid && ren_ready && ren_has_dst;
        cm_en       = cmt_valid && cmt_has_dst;
        release_tag = cm_en && !flush;
    end

    // Rename result fields.
    always_comb begin
        ren_new_tag    = ren_has_dst ? head_tag : '0;
        ren_prev_tag   = ren_has_dst ? dst_old  : '0;
        ren_prev_valid = ren_has_dst;
    end

    rename_map #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_a      (ren_src_a),
        .rd_b      (ren_src_b),
        .rd_d      (ren_dst),
        .tag_a     (ren_tag_a),
        .tag_b     (ren_tag_b),
        .tag_d     (dst_old),
        .wr_en     (alloc),
        .wr_idx    (ren_dst),
        .wr_tag    (head_tag),
        .cm_en     (cm_en),
        .cm_idx    (cmt_dst),
        .cm_tag    (cmt_new_tag),
        .flush     (flush),
        .used_mask (used_mask)
    );

    rename_free_list #(.NUM_PHYS(NUM_PHYS), .NUM_ARCH(NUM_ARCH)) u_free (
        .clk       (clk),
        .rst_n     (rst_n),
        .pop       (alloc),
        .push      (release_tag),
        .push_tag  (cmt_prev_tag),
        .rebuild   (flush),
        .used_mask (used_mask),
        .head_tag  (head_tag),
        .empty     (fl_empty)
    );

    assert_fresh_tag_differs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> (ren_new_tag != ren_prev_tag));
    assert_flush_blocks_rename_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !ren_ready);
endmodule

// File: tb/sim_reg_rename.sv
// Bench for reg_rename: a reference model of both tables, the pool and a reorder queue.
// Every output is compared on every cycle.
module sim_reg_rename;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       ren_valid, ren_has_dst, cmt_valid, cmt_has_dst, flush;
    logic [2:0] ren_src_a, ren_src_b, ren_dst, cmt_dst;
    logic [3:0] cmt_new_tag, cmt_prev_tag;
    logic       ren_ready, ren_prev_valid;
    logic [3:0] ren_tag_a, ren_tag_b, ren_new_tag, ren_prev_tag;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // Model state
    int spec_m[8];
    int cmt_m[8];
    int fl_q[8];
    int fl_h, fl_n;
    int rob_hd[64], rob_dst[64], rob_new[64], rob_prev[64];
    int rob_h, rob_n;
    logic [31:0] lf = 32'h1234_abcd;

    always #10 clk = ~clk;

    reg_rename u0 (
        .clk(clk), .rst_n(rst_n),
        .ren_valid(ren_valid), .ren_src_a(ren_src_a), .ren_src_b(ren_src_b),
        .ren_has_dst(ren_has_dst), .ren_dst(ren_dst), .ren_ready(ren_ready),
        .ren_tag_a(ren_tag_a), .ren_tag_b(ren_tag_b), .ren_new_tag(ren_new_tag),
        .ren_prev_tag(ren_prev_tag), .ren_prev_valid(ren_prev_valid),
        .cmt_valid(cmt_valid), .cmt_has_dst(cmt_has_dst), .cmt_dst(cmt_dst),
        .cmt_new_tag(cmt_new_tag), .cmt_prev_tag(cmt_prev_tag), .flush(flush)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic string pick(input string ctx, input string dflt);
        return (ctx != "") ? ctx : dflt;
    endfunction

    // One cycle: drive at negedge, check combinational outputs, then update the model at posedge.
    task automatic step(input bit v, input int a, input int b, input bit hd, input int d,
                        input bit cv, input bit fl, input string ctx);
        bit do_cmt, fire, exp_ready;
        int newtag, idx;
        @(negedge clk);
        do_cmt      = cv && (rob_n > 0);
        ren_valid   = v;
        ren_src_a   = 3'(a);
        ren_src_b   = 3'(b);
        ren_has_dst = hd;
        ren_dst     = 3'(d);
        flush       = fl;
        cmt_valid   = do_cmt;
        cmt_has_dst = do_cmt ? rob_hd[rob_h][0] : 1'b0;
        cmt_dst     = do_cmt ? 3'(rob_dst[rob_h]) : 3'd0;
        cmt_new_tag = do_cmt ? 4'(rob_new[rob_h]) : 4'd0;
        cmt_prev_tag = do_cmt ? 4'(rob_prev[rob_h]) : 4'd0;
        #5;
        exp_ready = !fl && (!hd || fl_n > 0);
        chk(pick(ctx, "R6"), int'(ren_ready), int'(exp_ready));
        chk(pick(ctx, "R2"), int'(ren_tag_a), spec_m[a]);
        chk(pick(ctx, "R2"), int'(ren_tag_b), spec_m[b]);
        if (hd) begin
            if (fl_n > 0) chk(pick(ctx, "R3"), int'(ren_new_tag), fl_q[fl_h]);
            chk(pick(ctx, "R4"), int'(ren_prev_tag), spec_m[d]);
            chk(pick(ctx, "R4"), int'(ren_prev_valid), 1);
        end else begin
            chk(pick(ctx, "R5"), int'(ren_prev_valid), 0);
        end
        fire = v && exp_ready;
        @(posedge clk);
        if (do_cmt) begin
            if (rob_hd[rob_h] != 0) begin
                cmt_m[rob_dst[rob_h]] = rob_new[rob_h];
            end
        end
        if (fl) begin
            for (int i = 0; i < 8; i++) spec_m[i] = cmt_m[i];
            fl_h = 0;
            fl_n = 0;
            for (int p = 0; p < 16; p++) begin
                bit used;
                used = 0;
                for (int i = 0; i < 8; i++) if (cmt_m[i] == p) used = 1;
                if (!used) begin
                    fl_q[fl_n] = p;
                    fl_n++;
                end
            end
            rob_n = 0;
            rob_h = 0;
        end else begin
            int rel;
            bit has_rel;
            has_rel = do_cmt && (rob_hd[rob_h] != 0);
            rel     = rob_prev[rob_h];
            if (do_cmt) begin
                rob_h = (rob_h + 1) % 64;
                rob_n--;
            end
            if (fire) begin
                newtag = 0;
                if (hd) begin
                    newtag    = fl_q[fl_h];
                    fl_h      = (fl_h + 1) % 8;
                    fl_n--;
                end
                idx = (rob_h + rob_n) % 64;
                rob_hd[idx]   = hd ? 1 : 0;
                rob_dst[idx]  = d;
                rob_new[idx]  = newtag;
                rob_prev[idx] = hd ? spec_m[d] : 0;
                rob_n++;
                if (hd) spec_m[d] = newtag;
            end
            if (has_rel) begin
                fl_q[(fl_h + fl_n) % 8] = rel;
                fl_n++;
            end
        end
    endtask

    task automatic sweep(input string ctx);
        for (int i = 0; i < 8; i++) step(0, i, 7 - i, 0, 0, 0, 0, ctx);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        ren_valid = 0; ren_has_dst = 0; cmt_valid = 0; cmt_has_dst = 0; flush = 0;
        ren_src_a = 0; ren_src_b = 0; ren_dst = 0; cmt_dst = 0;
        cmt_new_tag = 0; cmt_prev_tag = 0;
        for (int i = 0; i < 8; i++) begin spec_m[i] = i; cmt_m[i] = i; fl_q[i] = 8 + i; end
        fl_h = 0; fl_n = 8; rob_h = 0; rob_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset mapping, every source pair
        for (int a = 0; a < 8; a++)
            for (int b = 0; b < 8; b++) step(0, a, b, 0, 0, 0, 0, "R1");

        // R2/R3/R4: rename each register reading itself; the pool drains in order 8..15
        for (int i = 0; i < 8; i++) begin
            step(1, i, (i + 1) % 8, 1, i, 0, 0, "");
            chk("R3", spec_m[i], 8 + i);
        end

        // R6: empty pool stalls a destination write; state is untouched
        step(1, 3, 4, 1, 3, 0, 0, "R6");
        sweep("R6");

        // R5: no-destination request proceeds without touching the pool or table
        step(1, 2, 5, 0, 2, 0, 0, "R5");
        sweep("R5");

        // R7: a retired previous tag becomes the next allocation
        step(0, 0, 0, 0, 0, 1, 0, "R7");
        step(1, 5, 5, 1, 5, 0, 0, "R7");

        // R8: allocation and release in one cycle
        step(0, 0, 0, 0, 0, 1, 0, "R8");
        step(1, 1, 2, 1, 6, 1, 0, "R8");
        step(1, 6, 6, 1, 7, 0, 0, "R8");

        // R10: flush with a same-cycle commit, then check the restored map
        step(1, 0, 1, 1, 4, 1, 1, "R10");
        sweep("R10");

        // R9: flush with a pending rename; pool rebuilt in ascending order
        step(1, 0, 1, 1, 2, 0, 0, "");
        step(1, 3, 3, 1, 3, 0, 1, "R9");
        sweep("R9");
        for (int i = 0; i < 8; i++) step(1, i, i, 1, i, 0, 0, "R9");

        // Mixed traffic
        for (int n = 0; n < 4000; n++) begin
            lf = lf ^ (lf << 13);
            lf = lf ^ (lf >> 17);
            lf = lf ^ (lf << 5);
            step(lf[0] && (rob_n < 60), int'(lf[3:1]), int'(lf[6:4]), lf[7] | lf[8],
                 int'(lf[11:9]), lf[12] | lf[13], (lf[19:14] == 6'd0), "");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule